// File: doc/BRIEF.md
# LIFO Register Stack with Full/Empty Flags

This block is a self-contained last-in, first-out store of 64 words held in registers. A stack pointer always addresses the top item. Two status flags report whether the stack is completely full or completely empty. The surrounding datapath drives a data word and a single-cycle push or pop strobe. A pop returns the top word on a registered data output one clock later.

The pointer is only as wide as the address, so it wraps naturally. Starting from zero, the first push lands at address 1, and the sixty-fourth push wraps the pointer back to address 0. The flags are therefore not derived from a separate item count. A push that brings the pointer to zero marks the stack full, and a pop that brings it to zero marks it empty. A command that is illegal in the present state is discarded and flagged with a one-cycle error pulse. The illegal cases are a push while full, a pop while empty, or both strobes at once.

Top module: `lifo_regstack`

## Requirements
- R1: After reset the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the data output is 0.
- R2: A legal push (push strobe alone, stack not full) advances the pointer by one, modulo the depth, in the next cycle. It stores the data input at the advanced address, so the first item after reset goes to address 1.
- R3: After a legal push the empty flag is 0. The full flag is 1 exactly when the advanced pointer is 0, which is reached by the 64th stacked item.
- R4: A legal pop (pop strobe alone, stack not empty) loads the word at the current pointer onto the data output in the next cycle, and lowers the pointer by one, modulo the depth.
- R5: After a legal pop the full flag is 0. The empty flag is 1 exactly when the lowered pointer is 0. The two flags are never both 1.
- R6: A push while full raises the error output for one cycle and changes neither the pointer, the flags, the stored words nor the data output.
- R7: A pop while empty raises the error output for one cycle and changes neither the pointer, the flags nor the data output.
- R8: Push and pop asserted in the same cycle raise the error output for one cycle, and the command is ignored: pointer, flags and storage are unchanged.
- R9: Words come back in reverse order of storage, and the data output holds its last popped value until the next legal pop.
- R10: A cycle with neither strobe changes nothing and leaves the error output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Single-cycle push strobe |
| pop_i | input | 1 | Single-cycle pop strobe |
| wdata_i | input | WIDTH | Word to be pushed |
| rdata_o | output | WIDTH | Registered word from the most recent legal pop |
| ptr_o | output | log2(DEPTH) | Stack pointer, addresses the top item |
| full_o | output | 1 | Stack holds DEPTH items |
| empty_o | output | 1 | Stack holds no items |
| err_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
Directed sequences are run first, each aimed at one distinction:
- a pop on the freshly reset stack separates the empty-error path from a real pop;
- a short push/pop run shows the first item landing at pointer 1;
- filling to 64 items and pushing once more shows that the wrapped pointer of 0 means full rather than empty;
- draining the stack completely checks that the reverse ordering holds across the wrap.

Two biased random phases follow. The push-heavy phase keeps touching the full boundary, and the pop-heavy phase keeps touching the empty boundary. Both phases mix in idle cycles and simultaneous strobes, so ignored commands are seen next to legal ones.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_POP  = 2'd2,
    CMD_BAD  = 2'd3
  } cmd_e;

  // Decide what a strobe pair means in the present flag state.
  function automatic cmd_e classify(input logic push, input logic pop,
                                    input logic full, input logic empty);
    if (push && pop)   return CMD_BAD;
    if (push && full)  return CMD_BAD;
    if (pop && empty)  return CMD_BAD;
    if (push)          return CMD_PUSH;
    if (pop)           return CMD_POP;
    return CMD_IDLE;
  endfunction

endpackage

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] ptr_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output cmd_e          cmd_o
);

  // Pointer arithmetic relies on the AW-bit width for wraparound.
  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return p - AW'(1);
  endfunction

  logic [AW-1:0] ptr_q;
  logic          full_q, empty_q, err_q;
  logic [AW-1:0] ptr_up, ptr_dn;
  cmd_e          cmd;

  assign cmd    = classify(push_i, pop_i, full_q, empty_q);
  assign ptr_up = ptr_inc(ptr_q);
  assign ptr_dn = ptr_dec(ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (cmd == CMD_BAD);
      case (cmd)
        CMD_PUSH: begin
          ptr_q   <= ptr_up;
          full_q  <= (ptr_up == '0);
          empty_q <= 1'b0;
        end
        CMD_POP: begin
          ptr_q   <= ptr_dn;
          empty_q <= (ptr_dn == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ptr_o     = ptr_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;
  assign wr_en_o   = (cmd == CMD_PUSH);
  assign wr_addr_o = ptr_up;
  assign rd_en_o   = (cmd == CMD_POP);
  assign rd_addr_o = ptr_q;
  assign cmd_o     = cmd;

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= mem[rd_addr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import lifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [AW-1:0]    ptr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  // Named internal events, also observed by the bound checker.
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  cmd_e          cmd;
  logic          ev_push_ok, ev_pop_ok, ev_bad;

  lifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .ptr_o     (ptr_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .cmd_o     (cmd)
  );

  lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wdata_i   (wdata_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rdata_o   (rdata_o)
  );

  assign ev_push_ok = (cmd == CMD_PUSH);
  assign ev_pop_ok  = (cmd == CMD_POP);
  assign ev_bad     = (cmd == CMD_BAD);

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int AW = 6,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [AW-1:0]    ptr_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             err_o,
  input logic             ev_push_ok,
  input logic             ev_pop_ok
);

  p_push_moves_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> ptr_o == $past(ptr_o) + AW'(1));

  p_push_clears_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> !empty_o);

  p_pop_moves_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_ok |=> ptr_o == $past(ptr_o) - AW'(1));

  p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_ok |=> !full_o);

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  p_full_push_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(ptr_o) && $stable(rdata_o));

  p_empty_pop_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && $stable(ptr_o) && $stable(rdata_o));

  p_both_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> err_o && $stable(ptr_o) && $stable(full_o) && $stable(empty_o));

  p_data_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_pop_ok |=> $stable(rdata_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> !err_o && $stable(ptr_o) && $stable(full_o) && $stable(empty_o));

endmodule

bind lifo_regstack lifo_regstack_chk #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .rdata_o    (rdata_o),
  .ptr_o      (ptr_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .err_o      (err_o),
  .ev_push_ok (ev_push_ok),
  .ev_pop_ok  (ev_pop_ok)
);

// File: tb/lifo_regstack_bench.sv
module lifo_regstack_bench;

  localparam int DEPTH = 64;
  localparam int WIDTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push_i = 1'b0;
  logic             pop_i = 1'b0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic [WIDTH-1:0] rdata_o;
  logic [AW-1:0]    ptr_o;
  logic             full_o, empty_o, err_o;

  always #10 clk = ~clk;

  lifo_regstack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lifo_regstack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ptr_o(ptr_o),
    .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  int n_total = 0;
  int n_fail  = 0;

  // Reference model: a queue of stacked items plus a wrapping pointer.
  int m_items[$];
  int m_ptr   = 0;
  int m_rdata = 0;
  int m_err   = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag, string dtag);
    chk(tag,  "ptr",   int'(ptr_o),   m_ptr);
    chk(tag,  "full",  int'(full_o),  (m_items.size() == DEPTH) ? 1 : 0);
    chk(tag,  "empty", int'(empty_o), (m_items.size() == 0) ? 1 : 0);
    chk(tag,  "err",   int'(err_o),   m_err);
    chk(dtag, "rdata", int'(rdata_o), m_rdata);
  endtask

  // One command; called at a falling edge, returns at the next falling edge.
  task automatic step(bit p, bit q, int d);
    string tag;
    string dtag;
    push_i  = p;
    pop_i   = q;
    wdata_i = WIDTH'(d);
    m_err = 0;
    dtag  = "R9";
    if (p && q) begin
      tag = "R8"; m_err = 1;
    end else if (p && m_items.size() == DEPTH) begin
      tag = "R6"; m_err = 1;
    end else if (q && m_items.size() == 0) begin
      tag = "R7"; m_err = 1;
    end else if (p) begin
      m_items.push_back(d & ((1 << WIDTH) - 1));
      m_ptr = (m_ptr + 1) % DEPTH;
      tag = (m_items.size() == DEPTH) ? "R3" : "R2";
    end else if (q) begin
      m_rdata = m_items.pop_back();
      m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
      tag  = (m_items.size() == 0) ? "R5" : "R4";
      dtag = "R4";
    end else begin
      tag = "R10";
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag, dtag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ptr",   int'(ptr_o),   0);
    chk("R1", "empty", int'(empty_o), 1);
    chk("R1", "full",  int'(full_o),  0);
    chk("R1", "err",   int'(err_o),   0);
    chk("R1", "rdata", int'(rdata_o), 0);

    step(0, 0, 0);            // R10 idle
    step(0, 1, 0);            // R7 pop on empty
    step(0, 0, 0);            // err pulse lasts one cycle
    step(1, 0, 8'h11);        // R2 first item to address 1
    chk("R2", "first ptr", int'(ptr_o), 1);
    step(1, 0, 8'h22);
    step(1, 0, 8'h33);
    step(1, 1, 8'h44);        // R8 both strobes ignored
    step(0, 1, 0);            // R4 returns 0x33
    chk("R9", "lifo top", int'(rdata_o), 8'h33);
    step(0, 0, 0);            // R9 data held
    step(0, 1, 0);
    step(0, 1, 0);            // R5 back to empty
    step(0, 1, 0);            // R7 again

    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'hA0 ^ i);   // R3 fill to wrap
    chk("R3", "full at wrap", int'(full_o), 1);
    chk("R3", "ptr at wrap",  int'(ptr_o),  0);
    step(1, 0, 8'h5A);        // R6 push on full
    step(1, 1, 8'h5B);        // R8 while full
    step(0, 1, 0);            // pop the item at address 0
    chk("R9", "wrapped top", int'(rdata_o), (8'hA0 ^ (DEPTH - 1)));
    for (int i = 1; i < DEPTH; i++) step(0, 1, 0);            // R9 drain
    chk("R5", "drained empty", int'(empty_o), 1);

    // Biased random phases touching both boundaries.
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 65, (r >= 60 && r < 90), int'($urandom_range(0, 255)));
    end
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 30, (r >= 25 && r < 90), int'($urandom_range(0, 255)));
    end
    push_i = 1'b0;
    pop_i  = 1'b0;
    finish_run();
  end

endmodule